// File: doc/BRIEF.md
# Strap-Latched Clock Mode Controller

This block sits inside a clock generator and decides, once per power-on, how the generator's outputs behave. While the active-high power-on reset `por` is asserted, four pins shared with clock outputs are read as configuration straps. The straps carry a three-bit frequency select and one bus-mode bit. The last value seen before reset is released is kept in a four-bit register that does not change again until the next reset. After release, the shared pins are turned into outputs.

The latched select code chooses one of three modes. Code 3'b111 places every clock output in high impedance. Code 3'b011 is a production test mode, in which this block derives each output clock from the reference clock with integer dividers. One of these dividers divides by three with a duty cycle near 50%. The other six codes are normal modes: the synthesizer outside this block generates their frequencies, and this block only reports the code and whether the bus clock is synchronous.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While `por` is high, `latched_code` takes the value of `strap_in` at every rising edge of `clk_ref`. The bit mapping is: bit 0 = bus select, bit 1 = FS0, bit 2 = FS1, bit 3 = FS2.
- R2: Once `por` is low, `latched_code` holds the last value captured and ignores any change on `strap_in`.
- R3: While `por` is high, `pin_oe`, `clk_oe`, all mode flags and all test clocks are low. At the first rising edge with `por` low, `pin_oe` goes high and the mode flags take their decoded values.
- R4: A select code FS2..FS0 = 111 sets `mode_hiz` and keeps `clk_oe` low.
- R5: A select code FS2..FS0 = 011 sets `mode_test` and `clk_oe`. In that mode `tclk_cpu` and `tclk_48` run at REF/2 and `tclk_24` runs at REF/4.
- R6: In test mode, `tclk_bus` runs at REF/4 when the latched bus-select bit is 1 and at REF/3 when it is 0. The REF/3 clock is high for 1.5 reference periods out of 3.
- R7: All test clocks are low outside test mode. In test mode they start together: `tclk_cpu`, `tclk_48` and `tclk_24` first rise on the same edge, the second edge after reset release.
- R8: Any of the other six select codes sets `mode_normal` and `clk_oe`. In that case `bus_sync` equals the latched bus-select bit; `bus_sync` is 0 in the other modes.
- R9: After reset, exactly one of `mode_normal`, `mode_test` and `mode_hiz` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, active high, synchronous; also the strap capture window |
| strap_in | input | 4 | Levels read from the shared pins: {FS2, FS1, FS0, bus select} |
| latched_code | output | 4 | Held strap code |
| pin_oe | output | 1 | Turns the shared pins into outputs |
| clk_oe | output | 1 | Enables all clock output buffers |
| mode_normal | output | 1 | A normal frequency code is active |
| mode_test | output | 1 | Production test mode is active |
| mode_hiz | output | 1 | All clock outputs are in high impedance |
| bus_sync | output | 1 | In a normal mode, the bus clock is half the CPU clock |
| tclk_cpu | output | 1 | Test clock for CPU outputs, REF/2 |
| tclk_48 | output | 1 | Test clock for the 48 MHz output, REF/2 |
| tclk_24 | output | 1 | Test clock for the 24 MHz output, REF/4 |
| tclk_bus | output | 1 | Test clock for bus outputs, REF/4 or REF/3 |

## Verification
The captured code is registered at the rising edge, so the bench reads `latched_code` at the falling edge that follows each strap change during reset. The enables and mode flags are due one edge after the first non-reset edge, and the even test clocks rise one edge after that. For this reason the bench releases `por` at a falling edge and waits two rising edges before it compares these outputs at the next falling edge. The bench counts divider frequencies as rising edges over a 120-cycle window with a tolerance of one edge. It measures the REF/3 high time and period from timestamps taken on both edges of `tclk_bus`, because that output changes on the falling edge of the reference.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;
  localparam int STRAP_W   = 4;
  localparam int BSEL_BIT  = 0;
  localparam int FS_LSB    = 1;
  localparam int FS_W      = 3;
  localparam logic [FS_W-1:0] CODE_TEST = 3'b011;
  localparam logic [FS_W-1:0] CODE_HIZ  = 3'b111;

  typedef enum logic [1:0] {
    OP_NORMAL = 2'd0,
    OP_TEST   = 2'd1,
    OP_HIZ    = 2'd2
  } op_mode_e;

  function automatic op_mode_e classify(input logic [STRAP_W-1:0] code);
    logic [FS_W-1:0] fs;
    fs = code[FS_LSB +: FS_W];
    if (fs == CODE_HIZ)       return OP_HIZ;
    else if (fs == CODE_TEST) return OP_TEST;
    else                      return OP_NORMAL;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         capture,
  input  logic [W-1:0] pins,
  output logic [W-1:0] code
);
  // Capture window follows reset; the register keeps its value afterwards.
  always_ff @(posedge clk) begin
    if (capture) code <= pins;
  end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import strap_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] code,
  output logic               pin_oe,
  output logic               clk_oe,
  output logic               is_normal,
  output logic               is_test,
  output logic               is_hiz,
  output logic               bus_sync
);
  op_mode_e m;
  assign m = classify(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe    <= 1'b0;
      clk_oe    <= 1'b0;
      is_normal <= 1'b0;
      is_test   <= 1'b0;
      is_hiz    <= 1'b0;
      bus_sync  <= 1'b0;
    end else begin
      pin_oe    <= 1'b1;
      clk_oe    <= (m != OP_HIZ);
      is_normal <= (m == OP_NORMAL);
      is_test   <= (m == OP_TEST);
      is_hiz    <= (m == OP_HIZ);
      bus_sync  <= (m == OP_NORMAL) && code[BSEL_BIT];
    end
  end
endmodule

// File: rtl/int_div.sv
module int_div #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic run,
  output logic clk_o
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam int HI = (N % 2 == 1) ? (N + 1) / 2 : N / 2;
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam logic [CW-1:0] HI_C = CW'(HI);

  logic [CW-1:0] cnt;
  logic          q_p;

  always_ff @(posedge clk) begin
    if (!run) begin
      cnt <= '0;
      q_p <= 1'b0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      q_p <= (cnt < HI_C);
    end
  end

  generate
    if (N % 2 == 1) begin : g_odd
      // Half-cycle delayed copy trims the high phase to N/2 periods.
      logic q_n;
      always_ff @(negedge clk) begin
        if (!run) q_n <= 1'b0;
        else      q_n <= q_p;
      end
      assign clk_o = q_p & q_n;
    end else begin : g_even
      assign clk_o = q_p;
    end
  endgenerate
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import strap_mode_pkg::*;
#(
  parameter int CPU_DIV   = 2,
  parameter int F48_DIV   = 2,
  parameter int F24_DIV   = 4,
  parameter int BUS_S_DIV = 4,
  parameter int BUS_A_DIV = 3
) (
  input  logic               clk_ref,
  input  logic               por,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] latched_code,
  output logic               pin_oe,
  output logic               clk_oe,
  output logic               mode_normal,
  output logic               mode_test,
  output logic               mode_hiz,
  output logic               bus_sync,
  output logic               tclk_cpu,
  output logic               tclk_48,
  output logic               tclk_24,
  output logic               tclk_bus
);
  logic bus_s, bus_a;

  strap_latch #(.W(STRAP_W)) u_latch (
    .clk(clk_ref), .capture(por), .pins(strap_in), .code(latched_code)
  );

  mode_decode u_dec (
    .clk(clk_ref), .rst(por), .code(latched_code),
    .pin_oe(pin_oe), .clk_oe(clk_oe),
    .is_normal(mode_normal), .is_test(mode_test), .is_hiz(mode_hiz),
    .bus_sync(bus_sync)
  );

  // All dividers share one run enable so they leave reset on the same edge.
  int_div #(.N(CPU_DIV))   u_cpu (.clk(clk_ref), .run(mode_test), .clk_o(tclk_cpu));
  int_div #(.N(F48_DIV))   u_f48 (.clk(clk_ref), .run(mode_test), .clk_o(tclk_48));
  int_div #(.N(F24_DIV))   u_f24 (.clk(clk_ref), .run(mode_test), .clk_o(tclk_24));
  int_div #(.N(BUS_S_DIV)) u_bss (.clk(clk_ref), .run(mode_test), .clk_o(bus_s));
  int_div #(.N(BUS_A_DIV)) u_bsa (.clk(clk_ref), .run(mode_test), .clk_o(bus_a));

  assign tclk_bus = latched_code[BSEL_BIT] ? bus_s : bus_a;
endmodule

// File: rtl/strap_mode_ctrl_chk.sv
module strap_mode_ctrl_chk (
  input logic       clk_ref,
  input logic       por,
  input logic [3:0] latched_code,
  input logic       pin_oe,
  input logic       clk_oe,
  input logic       mode_normal,
  input logic       mode_test,
  input logic       mode_hiz,
  input logic       tclk_cpu,
  input logic       tclk_24
);
  logic por_d;
  always_ff @(posedge clk_ref) por_d <= por;

  a_r2_code_held: assert property (@(posedge clk_ref) disable iff (por)
    !$past(por) |-> $stable(latched_code));

  a_r3_pins_out: assert property (@(posedge clk_ref) disable iff (por)
    !$past(por) |-> pin_oe);

  a_r4_hiz_quiet: assert property (@(posedge clk_ref) disable iff (por)
    mode_hiz |-> !clk_oe);

  a_r7_aligned: assert property (@(posedge clk_ref) disable iff (por)
    $rose(tclk_24) |-> $rose(tclk_cpu));

  a_r9_one_mode: assert property (@(posedge clk_ref) disable iff (por)
    pin_oe |-> $onehot({mode_normal, mode_test, mode_hiz}));

  always @(negedge clk_ref) begin
    if (por_d === 1'b1) begin
      a_r3_quiet_in_reset: assert (!pin_oe && !clk_oe && !mode_test);
    end
  end
endmodule

bind strap_mode_ctrl strap_mode_ctrl_chk u_chk (
  .clk_ref(clk_ref), .por(por), .latched_code(latched_code),
  .pin_oe(pin_oe), .clk_oe(clk_oe), .mode_normal(mode_normal),
  .mode_test(mode_test), .mode_hiz(mode_hiz),
  .tclk_cpu(tclk_cpu), .tclk_24(tclk_24)
);

// File: tb/sim_strap_mode_ctrl.sv
`timescale 1ns/1ps
module sim_strap_mode_ctrl;
  logic clk_ref = 1'b0;
  logic por = 1'b1;
  logic [3:0] strap_in = 4'h0;
  logic [3:0] latched_code;
  logic pin_oe, clk_oe, mode_normal, mode_test, mode_hiz, bus_sync;
  logic tclk_cpu, tclk_48, tclk_24, tclk_bus;

  int n_run = 0, n_fail = 0;
  int e_cpu, e_48, e_24, e_bus;
  realtime t_rise = 0, bus_hi = 0, bus_per = 0;

  always #10 clk_ref = ~clk_ref;

  strap_mode_ctrl u0 (.*);

  always @(posedge tclk_cpu) e_cpu++;
  always @(posedge tclk_48)  e_48++;
  always @(posedge tclk_24)  e_24++;
  always @(posedge tclk_bus) begin
    e_bus++;
    if (t_rise > 0) bus_per = $realtime - t_rise;
    t_rise = $realtime;
  end
  always @(negedge tclk_bus) bus_hi = $realtime - t_rise;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_test(input logic [3:0] c); return c[3:1] == 3'b011; endfunction
  function automatic bit is_hiz(input logic [3:0] c);  return c[3:1] == 3'b111; endfunction

  function automatic bit near(input int a, input int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  task automatic run_code(input logic [3:0] code);
    bit t, h;
    t = is_test(code);
    h = is_hiz(code);
    @(negedge clk_ref);
    por = 1'b1;
    strap_in = 4'($urandom);
    @(posedge clk_ref); @(negedge clk_ref);
    strap_in = code;
    @(posedge clk_ref); @(negedge clk_ref);
    check(latched_code == code, "R1 capture", latched_code, code);
    check(!pin_oe && !clk_oe, "R3 off in reset", {pin_oe, clk_oe}, 0);
    check(!tclk_cpu && !tclk_24 && !mode_test, "R3 quiet in reset", tclk_cpu, 0);
    por = 1'b0;
    strap_in = ~code;
    @(posedge clk_ref); @(posedge clk_ref); @(negedge clk_ref);
    check(latched_code == code, "R2 hold", latched_code, code);
    check(pin_oe == 1'b1, "R3 pins out", pin_oe, 1);
    check(clk_oe == !h, "R4/R5/R8 clk_oe", clk_oe, !h);
    check(mode_hiz == h, "R4 hiz flag", mode_hiz, h);
    check(mode_test == t, "R5 test flag", mode_test, t);
    check(mode_normal == (!t && !h), "R8 normal flag", mode_normal, !t && !h);
    check(bus_sync == (!t && !h && code[0]), "R8 bus_sync", bus_sync, !t && !h && code[0]);
    check($countones({mode_normal, mode_test, mode_hiz}) == 1, "R9 one mode",
          $countones({mode_normal, mode_test, mode_hiz}), 1);
    if (t) check(tclk_cpu && tclk_48 && tclk_24, "R7 aligned start",
                 {tclk_cpu, tclk_48, tclk_24}, 7);
    e_cpu = 0; e_48 = 0; e_24 = 0; e_bus = 0;
    t_rise = 0; bus_hi = 0; bus_per = 0;
    strap_in = 4'($urandom);
    repeat (120) @(posedge clk_ref);
    @(negedge clk_ref);
    check(latched_code == code, "R2 hold late", latched_code, code);
    if (t) begin
      check(near(e_cpu, 60), "R5 cpu REF/2", e_cpu, 60);
      check(near(e_48, 60),  "R5 f48 REF/2", e_48, 60);
      check(near(e_24, 30),  "R5 f24 REF/4", e_24, 30);
      if (code[0]) begin
        check(near(e_bus, 30), "R6 bus REF/4", e_bus, 30);
        check(int'(bus_per) == 80, "R6 bus period /4", int'(bus_per), 80);
      end else begin
        check(near(e_bus, 40), "R6 bus REF/3", e_bus, 40);
        check(int'(bus_per) == 60, "R6 bus period /3", int'(bus_per), 60);
        check(int'(bus_hi) == 30, "R6 bus duty /3", int'(bus_hi), 30);
      end
    end else begin
      check(e_cpu + e_48 + e_24 + e_bus == 0, "R7 idle outside test",
            e_cpu + e_48 + e_24 + e_bus, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_ref);
    for (int c = 0; c < 16; c++) run_code(4'(c));
    run_code(4'b0110);
    run_code(4'b0111);
    for (int k = 0; k < 8; k++) run_code(4'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule